// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer with Two-Bit Predictor

This block sits beside the program counter in the fetch stage. Every cycle it is looked up with the current fetch address. It returns the address to fetch next. When the lookup hits a stored branch whose two-bit confidence counter leans toward taken, the next address is the stored target. The redirect happens in the same cycle, so a taken branch pays no penalty for computing its target. In every other case the next address is the sequential one, `lookup_pc + 4`, which means the default is to predict not taken.

When a branch resolves later in the pipeline, the pipeline presents it on an update port. The update carries the branch address, whether the instruction really is a branch, the outcome, the actual target, and the next address that fetch predicted for it. The block then trains the counter and installs or refreshes the entry. In the same cycle it raises a mispredict flag together with the correct address to fetch from. The table is direct-mapped, has 2^IDX_W entries and is kept in flops.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup gives `pred_taken` = 0 and `pred_next_pc` = `lookup_pc + 4`.
- R2: The entry is selected by PC bits [IDX_W+1:2], which are [5:2] by default. It matches only when its valid bit is set and its stored tag equals PC bits [ADDR_W-1:IDX_W+2]. PC bits [1:0] take no part in the match.
- R3: On a match whose counter is 2'b10 or 2'b11, `pred_taken` = 1 and `pred_next_pc` is the stored target, combinationally in the same cycle.
- R4: On a miss, or on a match whose counter is 2'b00 or 2'b01, `pred_taken` = 0 and `pred_next_pc` = `lookup_pc + 4`.
- R5: A taken branch update that misses installs its tag and target with the counter at 2'b10. Lookups see the new entry from the following cycle on.
- R6: A not-taken branch update that misses leaves the table unchanged.
- R7: A branch update that hits adds one to the counter when taken and subtracts one when not taken. The counter saturates at 2'b11 and at 2'b00.
- R8: An entry at 2'b11 still predicts taken after one not-taken outcome. It takes two successive not-taken outcomes to flip it to not taken.
- R9: A taken branch update that hits overwrites the stored target with the new target.
- R10: The resolved next PC is `upd_target` for a taken branch and `upd_pc + 4` otherwise. `redirect_pc` always shows it. `mispredict` is high exactly when `upd_valid` is high and `upd_pred_next_pc` differs from it.
- R11: An update with `upd_is_branch` = 0 changes no entry, although it can still raise `mispredict` under R10.
- R12: A taken branch that maps to an occupied index with a different tag replaces that entry (counter 2'b10). After that, the old branch misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_pc | input | ADDR_W | Current fetch address |
| pred_next_pc | output | ADDR_W | Predicted next fetch address |
| pred_taken | output | 1 | Lookup hit with a taken prediction |
| upd_valid | input | 1 | Resolved instruction presented this cycle |
| upd_is_branch | input | 1 | Resolved instruction is a branch |
| upd_taken | input | 1 | Actual branch outcome |
| upd_pc | input | ADDR_W | Address of the resolved instruction |
| upd_target | input | ADDR_W | Actual branch target |
| upd_pred_next_pc | input | ADDR_W | Next address that fetch predicted for it |
| mispredict | output | 1 | Prediction was wrong; re-fetch |
| redirect_pc | output | ADDR_W | Correct next address |

## Verification
A corrupted counter shows up as a wrong `pred_next_pc` on the first lookup of that address after the fault. For an entry that sits one step from the threshold, it may only show up after one more training update. A wrong tag, valid bit or target shows up on the next lookup that maps to that index, which is one cycle after the update. The bench therefore follows every update with a lookup of the same address and compares the result against a model built from the requirements. The mispredict flag and the redirect address are combinational, so any fault there shows up in the cycle of the update itself.

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lookup_pc,
  output logic [ADDR_W-1:0] pred_next_pc,
  output logic              pred_taken,
  input  logic              upd_valid,
  input  logic              upd_is_branch,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic [ADDR_W-1:0] upd_pred_next_pc,
  output logic              mispredict,
  output logic [ADDR_W-1:0] redirect_pc
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - 2 - IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [1:0]         ctr_q  [ENTRIES];
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q  [ENTRIES];

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic             lk_hit, up_hit, up_br;

  assign lk_idx = lookup_pc[IDX_W+1:2];
  assign lk_tag = lookup_pc[ADDR_W-1:IDX_W+2];
  assign up_idx = upd_pc[IDX_W+1:2];
  assign up_tag = upd_pc[ADDR_W-1:IDX_W+2];

  assign lk_hit       = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign pred_taken   = lk_hit && ctr_q[lk_idx][1];
  assign pred_next_pc = pred_taken ? tgt_q[lk_idx] : lookup_pc + ADDR_W'(4);

  assign up_br       = upd_valid && upd_is_branch;
  assign up_hit      = valid_q[up_idx] && (tag_q[up_idx] == up_tag);
  assign redirect_pc = (up_br && upd_taken) ? upd_target : upd_pc + ADDR_W'(4);
  assign mispredict  = upd_valid && (upd_pred_next_pc != redirect_pc);

  function automatic logic [1:0] step(input logic [1:0] c, input logic tk);
    if (tk) step = (c == 2'b11) ? c : c + 2'b01;
    else    step = (c == 2'b00) ? c : c - 2'b01;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= 2'b00;
    end else if (up_br) begin
      if (up_hit) begin
        ctr_q[up_idx] <= step(ctr_q[up_idx], upd_taken);
      end else if (upd_taken) begin
        valid_q[up_idx] <= 1'b1;
        ctr_q[up_idx]   <= 2'b10;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && up_br && upd_taken) begin
      tag_q[up_idx] <= up_tag;
      tgt_q[up_idx] <= upd_target;
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  assert_reset_clears_R1: assert property (@(posedge clk)
    disable iff (!rst_n) (armed && !$past(armed)) |-> (valid_q == '0));

  assert_alloc_weak_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(up_br && !up_hit && upd_taken)) |->
      (valid_q[$past(up_idx)] && ctr_q[$past(up_idx)] == 2'b10));

  assert_nt_miss_no_alloc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(up_br && !up_hit && !upd_taken)) |->
      (valid_q[$past(up_idx)] == $past(valid_q[up_idx])));

  assert_ctr_saturate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(up_br && up_hit && upd_taken && ctr_q[up_idx] == 2'b11)) |->
      (ctr_q[$past(up_idx)] == 2'b11));

  assert_mispredict_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> upd_valid);

  assert_non_branch_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(upd_valid && !upd_is_branch)) |-> (valid_q == $past(valid_q)));
endmodule

// File: tb/sim_btb_predictor.sv
module sim_btb_predictor;
  logic        clk = 0, rst_n = 0;
  logic [31:0] lookup_pc = 0, pred_next_pc;
  logic        pred_taken;
  logic        upd_valid = 0, upd_is_branch = 0, upd_taken = 0;
  logic [31:0] upd_pc = 0, upd_target = 0, upd_pred_next_pc = 0;
  logic        mispredict;
  logic [31:0] redirect_pc;

  int vectors = 0, fails = 0;

  btb_predictor u0 (.clk, .rst_n, .lookup_pc, .pred_next_pc, .pred_taken,
    .upd_valid, .upd_is_branch, .upd_taken, .upd_pc, .upd_target,
    .upd_pred_next_pc, .mispredict, .redirect_pc);

  always #10 clk = ~clk;

  logic        mv [16];
  logic [25:0] mtag [16];
  logic [31:0] mtgt [16];
  logic [1:0]  mctr [16];
  logic [31:0] rng = 32'h1234_5678;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  function automatic logic mhit(input logic [31:0] pc);
    return mv[pc[5:2]] && mtag[pc[5:2]] == pc[31:6];
  endfunction

  function automatic logic [31:0] mpred(input logic [31:0] pc);
    return (mhit(pc) && mctr[pc[5:2]][1]) ? mtgt[pc[5:2]] : pc + 32'd4;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input string req, input logic [31:0] pc);
    @(negedge clk);
    lookup_pc = pc;
    #1;
    chk(req, pred_next_pc, mpred(pc));
    chk(req, {31'd0, pred_taken}, {31'd0, mhit(pc) && mctr[pc[5:2]][1]});
  endtask

  task automatic upd(input logic [31:0] pc, input logic br, input logic tk,
                     input logic [31:0] tgt, input logic [31:0] pn);
    logic [31:0] res;
    logic [3:0]  i;
    @(negedge clk);
    upd_valid = 1; upd_pc = pc; upd_is_branch = br; upd_taken = tk;
    upd_target = tgt; upd_pred_next_pc = pn;
    res = (br && tk) ? tgt : pc + 32'd4;
    #1;
    chk("R10 redirect", redirect_pc, res);
    chk("R10 mispredict", {31'd0, mispredict}, {31'd0, pn != res});
    @(posedge clk);
    i = pc[5:2];
    if (br) begin
      if (mhit(pc)) begin
        if (tk) begin mctr[i] = (mctr[i] == 3) ? 2'd3 : mctr[i] + 1; mtgt[i] = tgt; end
        else         mctr[i] = (mctr[i] == 0) ? 2'd0 : mctr[i] - 1;
      end else if (tk) begin
        mv[i] = 1; mtag[i] = pc[31:6]; mtgt[i] = tgt; mctr[i] = 2'b10;
      end
    end
    #1 upd_valid = 0;
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] p, q;
    for (int i = 0; i < 16; i++) mv[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    for (int i = 0; i < 16; i++) look("R1 reset", {26'h55, i[3:0], 2'b00});

    p = 32'h0000_4010;
    upd(p, 1, 0, 32'h9000, p + 4);
    look("R6 nt miss", p);
    upd(p, 1, 1, 32'h9000, p + 4);
    look("R5 alloc", p);
    look("R3 taken hit", p);
    look("R2 low bits ignored", p | 32'd3);
    upd(p, 1, 1, 32'h9100, 32'h9000);
    look("R9 target refresh", p);
    upd(p, 1, 1, 32'h9100, 32'h9100);
    upd(p, 1, 1, 32'h9100, 32'h9100);
    look("R7 saturate high", p);
    upd(p, 1, 0, 32'h9100, 32'h9100);
    look("R8 one nt keeps taken", p);
    chk("R8 still taken", {31'd0, pred_taken}, 32'd1);
    upd(p, 1, 0, 32'h9100, 32'h9100);
    look("R8 two nt flips", p);
    chk("R4 weak nt", {31'd0, pred_taken}, 32'd0);
    upd(p, 1, 0, 32'h9100, p + 4);
    upd(p, 1, 0, 32'h9100, p + 4);
    upd(p, 1, 1, 32'h9100, p + 4);
    look("R7 saturate low", p);
    chk("R7 low stays nt", {31'd0, pred_taken}, 32'd0);
    upd(p, 1, 1, 32'h9100, p + 4);
    look("R7 climb", p);
    chk("R7 climbed", {31'd0, pred_taken}, 32'd1);

    upd(p, 0, 1, 32'hAAAA, 32'h9100);
    look("R11 non-branch", p);
    chk("R11 still taken", {31'd0, pred_taken}, 32'd1);

    q = 32'h0007_0010;
    upd(q, 1, 1, 32'hBEE0, q + 4);
    look("R12 replace new", q);
    look("R12 old misses", p);
    chk("R12 old nt", {31'd0, pred_taken}, 32'd0);

    for (int s = 0; s < 3000; s++) begin
      logic [31:0] pc, tg, pn;
      logic br, tk;
      rng = nxt(rng);
      pc = {rng[31] ? 26'h2A5 : 26'h100, rng[3:0], 2'b00};
      br = rng[6:4] != 3'd0;
      tk = rng[7] | rng[8];
      tg = {16'h00C0, rng[23:10], 2'b00};
      look("R3 R4 sweep", pc);
      pn = (rng[11:9] == 3'd0) ? pc + 32'd8 : mpred(pc);
      upd(pc, br, tk, tg, pn);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule